// File: doc/BRIEF.md
# Ring Bus Mediator

The mediator is the one clocked node on a four-wire ring bus whose other members have no clock of their own. While the ring is idle it keeps the loop open and drives both its outgoing data and outgoing clock high. A falling edge coming back on its data input, or a transmit request from the local node, counts as a wakeup. The mediator then asks the power manager for high-power mode and waits for the acknowledge. Only after the acknowledge does it start clocking the ring.

Each clocked transaction has a fixed shape. First come four bring-up clock periods and one arbitration period, during which the mediator keeps its data output high. If some downstream node holds data low at the end of arbitration, that node owns the bus, and the mediator closes the loop by forwarding data for a fixed number of bit periods. If no member is requesting, a pending local request is granted instead. If nobody is requesting at all, the transaction is a null one.

Every transaction ends with an in-band interrupt: three rising edges on data while the clock stays high. The lines then return high, and the power request is kept for a fixed linger time before it is released. A new request during the linger time restarts clocking at once.

Top module: `ring_mediator`

## Requirements
- R1: After reset, and whenever the mediator is idle, ringDataOut and ringClkOut are both 1, pwrReq is 0 and txGrant is 0.
- R2: In idle, a 1-to-0 transition on ringDataIn, or a 1 on localTxReq, raises pwrReq within five system cycles.
- R3: ringClkOut does not change while pwrReq is 0, or while the mediator is waiting for pwrAck to become 1.
- R4: Once clocking has started, every low phase and every high phase of ringClkOut inside a transaction lasts exactly HALF_DIV system cycles.
- R5: Each transaction begins with exactly four bring-up clock periods followed by one arbitration period. A transaction with no requester therefore has exactly five ringClkOut rising edges.
- R6: ringDataOut is 1 at each of the first five ringClkOut rising edges of a transaction, whatever the level of ringDataIn.
- R7: At the end of arbitration, a 0 on ringDataIn means a member owns the bus and txGrant stays 0. If ringDataIn is 1 and a local request is pending, txGrant pulses for one cycle. A local request that loses is kept and served in a later transaction.
- R8: When a transaction is owned, ringDataOut follows ringDataIn combinationally for MSG_BITS clock periods, giving 5 + MSG_BITS rising edges in total.
- R9: Every transaction ends with exactly three rising edges on ringDataOut while ringClkOut stays at 1.
- R10: After the interrupt, ringDataOut and ringClkOut are 1. pwrReq falls exactly HALF_DIV + IDLE_WAIT system cycles after the last interrupt rising edge.
- R11: A request that arrives before pwrReq is released starts a new transaction without waiting for pwrAck, and pwrReq stays 1 in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of the mediator |
| rstN | input | 1 | Active-low asynchronous reset |
| ringDataIn | input | 1 | Data returning from the last ring member |
| ringDataOut | output | 1 | Data driven to the first ring member |
| ringClkOut | output | 1 | Ring clock driven to the first ring member |
| pwrReq | output | 1 | Request for high-power mode to the power manager |
| pwrAck | input | 1 | Power manager reports high-power mode is ready |
| localTxReq | input | 1 | Local node asks for the bus (one-cycle pulse is enough) |
| txGrant | output | 1 | One-cycle pulse: local node won arbitration |

## Verification
The bench holds the power acknowledge low for a long stretch to catch a mediator that clocks before power is ready; such a design would show ring clock edges while still waiting. It holds ringDataIn low through bring-up. A mediator that forwarded data too early would show a low ringDataOut at a bring-up edge, and one that sampled at the wrong moment would misjudge the winner. It pits a member against a local request to confirm that the member wins and that the losing request is served after the interrupt, without pwrReq dropping. It also drops the acknowledge during the linger time and then requests again. A design that re-ran the power handshake at that point would stall with no clock edges.

// File: rtl/ring_med_pkg.sv
package ring_med_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_WAKE,
    ST_ARB,
    ST_DATA,
    ST_INTR,
    ST_LINGER
  } medState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clkLow;
    logic clkHigh;
    logic dataLow;
    logic dataHigh;
    logic forward;
  } medStrobe_t;
endpackage

// File: rtl/ring_med_datapath.sv
module ring_med_datapath #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ringDataIn,
  input  ring_med_pkg::medStrobe_t stb,
  output logic                    ringDataOut,
  output logic                    ringClkOut,
  output logic                    dinLevel,
  output logic                    dinFall
);
  logic                  clkReg;
  logic                  dataReg;
  logic [SYNC_DEPTH-1:0] dinSyncChain;
  logic                  dinPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkReg       <= 1'b1;
      dataReg      <= 1'b1;
      dinSyncChain <= '1;
      dinPrev      <= 1'b1;
    end else begin
      if (stb.clkLow)       clkReg <= 1'b0;
      else if (stb.clkHigh) clkReg <= 1'b1;
      if (stb.dataLow)       dataReg <= 1'b0;
      else if (stb.dataHigh) dataReg <= 1'b1;
      dinSyncChain <= {dinSyncChain[SYNC_DEPTH-2:0], ringDataIn};
      dinPrev      <= dinSyncChain[SYNC_DEPTH-1];
    end
  end

  assign dinLevel    = dinSyncChain[SYNC_DEPTH-1];
  assign dinFall     = dinPrev & ~dinLevel;
  assign ringClkOut  = clkReg;
  assign ringDataOut = stb.forward ? ringDataIn : dataReg;
endmodule

// File: rtl/ring_med_ctrl.sv
module ring_med_ctrl #(
  parameter int HALF_DIV     = 4,
  parameter int WAKE_PERIODS = 4,
  parameter int MSG_BITS     = 8,
  parameter int INT_EDGES    = 3,
  parameter int IDLE_WAIT    = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     dinLevel,
  input  logic                     dinFall,
  input  logic                     pwrAck,
  input  logic                     localTxReq,
  output ring_med_pkg::medStrobe_t stb,
  output ring_med_pkg::medState_t  curState,
  output logic                     pwrReq,
  output logic                     txGrant
);
  import ring_med_pkg::*;

  localparam int PH_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_MAX = (MSG_BITS > WAKE_PERIODS) ?
                           ((MSG_BITS > INT_EDGES) ? MSG_BITS : INT_EDGES) :
                           ((WAKE_PERIODS > INT_EDGES) ? WAKE_PERIODS : INT_EDGES);
  localparam int BIT_W   = $clog2(BIT_MAX + 1);
  localparam int LW      = (IDLE_WAIT > 1) ? $clog2(IDLE_WAIT) : 1;
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] WAKE_LAST = BIT_W'(WAKE_PERIODS - 1);
  localparam logic [BIT_W-1:0] MSG_LAST  = BIT_W'(MSG_BITS - 1);
  localparam logic [BIT_W-1:0] INT_LAST  = BIT_W'(INT_EDGES - 1);
  localparam logic [LW-1:0]    LING_LAST = LW'(IDLE_WAIT - 1);

  medState_t        state, nxt;
  logic [PH_W-1:0]  phCnt;
  logic             halfHigh;
  logic [BIT_W-1:0] bitCnt;
  logic [LW-1:0]    lingerCnt;
  logic             localPend;
  logic             grantNow;
  logic             phaseEnd;
  logic             clocked;
  logic             wantBus;

  assign phaseEnd = (phCnt == PH_LAST);
  assign clocked  = (state == ST_WAKE) || (state == ST_ARB) ||
                    (state == ST_DATA) || (state == ST_INTR);
  assign wantBus  = dinFall | localTxReq | localPend;

  always_comb begin
    nxt      = state;
    stb      = '0;
    grantNow = 1'b0;
    case (state)
      ST_IDLE:  if (wantBus) nxt = ST_PWRUP;
      ST_PWRUP: if (pwrAck) begin nxt = ST_WAKE; stb.clkLow = 1'b1; end
      ST_WAKE: if (phaseEnd) begin
        if (!halfHigh) stb.clkHigh = 1'b1;
        else begin
          stb.clkLow = 1'b1;
          if (bitCnt == WAKE_LAST) nxt = ST_ARB;
        end
      end
      ST_ARB: if (phaseEnd) begin
        if (!halfHigh) stb.clkHigh = 1'b1;
        else if (!dinLevel || localPend) begin
          nxt        = ST_DATA;
          stb.clkLow = 1'b1;
          grantNow   = dinLevel;
        end else begin
          nxt         = ST_INTR;
          stb.dataLow = 1'b1;
        end
      end
      ST_DATA: begin
        stb.forward = 1'b1;
        if (phaseEnd) begin
          if (!halfHigh) stb.clkHigh = 1'b1;
          else if (bitCnt == MSG_LAST) begin nxt = ST_INTR; stb.dataLow = 1'b1; end
          else stb.clkLow = 1'b1;
        end
      end
      ST_INTR: if (phaseEnd) begin
        if (!halfHigh) stb.dataHigh = 1'b1;
        else if (bitCnt == INT_LAST) nxt = ST_LINGER;
        else stb.dataLow = 1'b1;
      end
      ST_LINGER: begin
        if (wantBus) begin nxt = ST_WAKE; stb.clkLow = 1'b1; end
        else if (lingerCnt == LING_LAST) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phCnt     <= '0;
      halfHigh  <= 1'b0;
      bitCnt    <= '0;
      lingerCnt <= '0;
      localPend <= 1'b0;
      txGrant   <= 1'b0;
    end else begin
      state   <= nxt;
      txGrant <= grantNow;
      if (localTxReq)    localPend <= 1'b1;
      else if (grantNow) localPend <= 1'b0;
      if (nxt != state) begin
        phCnt     <= '0;
        halfHigh  <= 1'b0;
        bitCnt    <= '0;
        lingerCnt <= '0;
      end else begin
        phCnt <= phaseEnd ? '0 : phCnt + 1'b1;
        if (phaseEnd) halfHigh <= ~halfHigh;
        if (phaseEnd && halfHigh && clocked) bitCnt <= bitCnt + 1'b1;
        if (state == ST_LINGER) lingerCnt <= lingerCnt + 1'b1;
      end
    end
  end

  assign pwrReq   = (state != ST_IDLE);
  assign curState = state;

  // a grant is only ever issued on the way out of arbitration
  assert_grant_after_arb_R7: assert property (@(posedge clk) disable iff (!rstN)
    txGrant |-> ($past(state) == ST_ARB && state == ST_DATA));
endmodule

// File: rtl/ring_mediator.sv
module ring_mediator #(
  parameter int HALF_DIV     = 4,
  parameter int WAKE_PERIODS = 4,
  parameter int MSG_BITS     = 8,
  parameter int INT_EDGES    = 3,
  parameter int IDLE_WAIT    = 16,
  parameter int SYNC_DEPTH   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ringDataIn,
  output logic ringDataOut,
  output logic ringClkOut,
  output logic pwrReq,
  input  logic pwrAck,
  input  logic localTxReq,
  output logic txGrant
);
  import ring_med_pkg::*;

  medStrobe_t stb;
  medState_t  curState;
  logic       dinLevel;
  logic       dinFall;

  ring_med_ctrl #(
    .HALF_DIV(HALF_DIV), .WAKE_PERIODS(WAKE_PERIODS), .MSG_BITS(MSG_BITS),
    .INT_EDGES(INT_EDGES), .IDLE_WAIT(IDLE_WAIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .dinLevel(dinLevel), .dinFall(dinFall),
    .pwrAck(pwrAck), .localTxReq(localTxReq), .stb(stb),
    .curState(curState), .pwrReq(pwrReq), .txGrant(txGrant)
  );

  ring_med_datapath #(.SYNC_DEPTH(SYNC_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ringDataIn(ringDataIn), .stb(stb),
    .ringDataOut(ringDataOut), .ringClkOut(ringClkOut),
    .dinLevel(dinLevel), .dinFall(dinFall)
  );

  assert_idle_lines_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE) |-> (ringClkOut && ringDataOut));

  assert_clock_needs_power_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ringClkOut != $past(ringClkOut)) |-> pwrReq);

  assert_no_clock_in_pwrup_R3: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_PWRUP) |-> ringClkOut);

  assert_wake_data_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_WAKE || curState == ST_ARB) |-> ringDataOut);

  assert_intr_clock_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_INTR) |-> ringClkOut);
endmodule

// File: tb/ring_mediator_tb.sv
module ring_mediator_tb;
  localparam int HALF      = 4;
  localparam int MSG       = 8;
  localparam int IDLE_WAIT = 16;

  logic clk = 1'b0;
  logic rstN;
  logic ringDataIn;
  logic ringDataOut;
  logic ringClkOut;
  logic pwrReq;
  logic pwrAck;
  logic localTxReq;
  logic txGrant;
  logic pmuHold;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ring_mediator #(.HALF_DIV(HALF), .MSG_BITS(MSG), .IDLE_WAIT(IDLE_WAIT)) u_dut (
    .clk(clk), .rstN(rstN), .ringDataIn(ringDataIn), .ringDataOut(ringDataOut),
    .ringClkOut(ringClkOut), .pwrReq(pwrReq), .pwrAck(pwrAck),
    .localTxReq(localTxReq), .txGrant(txGrant)
  );

  // power manager model
  always @(posedge clk) pwrAck <= pmuHold ? 1'b0 : pwrReq;

  // observer, sampled on the falling system clock edge
  int  cyc = 0, lastTog = 0, riseTot = 0, fallTot = 0, phaseErr = 0;
  int  wakeDataErr = 0, txRise = 0, dataRiseSinceClk = 0, lastDataRise = 0;
  int  pwrFalls = 0, pwrFallCyc = 0, grants = 0, grantAtRise = 0;
  bit  sawIdle = 1'b1;
  logic prevClk = 1'b1, prevData = 1'b1, prevPwr = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (ringClkOut !== prevClk) begin
      int span;
      span = cyc - lastTog;
      lastTog = cyc;
      dataRiseSinceClk = 0;
      if (ringClkOut) begin
        riseTot++;
        if (span != HALF) phaseErr++;
        if (txRise < 5 && ringDataOut !== 1'b1) wakeDataErr++;
        txRise++;
      end else begin
        fallTot++;
        if (!sawIdle && span != HALF) phaseErr++;
        sawIdle = 1'b0;
      end
    end else if (ringDataOut === 1'b1 && prevData === 1'b0) begin
      dataRiseSinceClk++;
      lastDataRise = cyc;
      if (dataRiseSinceClk == 3) begin sawIdle = 1'b1; txRise = 0; end
    end
    if (pwrReq === 1'b0 && prevPwr === 1'b1) begin
      pwrFalls++; pwrFallCyc = cyc; sawIdle = 1'b1; txRise = 0;
    end
    if (txGrant === 1'b1) begin grants++; grantAtRise = riseTot; end
    prevClk = ringClkOut; prevData = ringDataOut; prevPwr = pwrReq;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic waitPwrLow(input string req);
    int t = 0;
    while (pwrReq !== 1'b0 && t < 2000) begin cycles(1); t++; end
    check(pwrReq === 1'b0, req, t, 0);
    @(negedge clk); #1;
  endtask

  task automatic waitRises(input int target);
    int t = 0;
    while (riseTot < target && t < 2000) begin cycles(1); t++; end
  endtask

  task automatic testReset;
    @(negedge clk); #1;
    check(ringDataOut === 1'b1, "R1 data idle", ringDataOut, 1);
    check(ringClkOut === 1'b1, "R1 clk idle", ringClkOut, 1);
    check(pwrReq === 1'b0, "R1 pwrReq idle", pwrReq, 0);
    check(txGrant === 1'b0, "R1 grant idle", txGrant, 0);
  endtask

  task automatic testNull;
    int r0 = riseTot, f0 = fallTot, p0 = phaseErr, w0 = wakeDataErr, g0 = grants;
    pmuHold = 1'b1;
    ringDataIn = 1'b0;
    cycles(5);
    check(pwrReq === 1'b1, "R2 wakeup on fall", pwrReq, 1);
    ringDataIn = 1'b1;
    cycles(30);
    check(riseTot == r0 && fallTot == f0, "R3 no clock before ack",
          riseTot + fallTot - r0 - f0, 0);
    check(ringClkOut === 1'b1, "R3 clock held high", ringClkOut, 1);
    pmuHold = 1'b0;
    waitPwrLow("R10 pwr release");
    check(riseTot - r0 == 5, "R5 null edges", riseTot - r0, 5);
    check(dataRiseSinceClk == 3, "R9 interrupt edges", dataRiseSinceClk, 3);
    check(pwrFallCyc - lastDataRise == HALF + IDLE_WAIT, "R10 linger time",
          pwrFallCyc - lastDataRise, HALF + IDLE_WAIT);
    check(ringDataOut === 1'b1 && ringClkOut === 1'b1, "R10 lines high",
          {ringDataOut, ringClkOut}, 3);
    check(phaseErr == p0, "R4 phase lengths", phaseErr - p0, 0);
    check(wakeDataErr == w0, "R6 data high in wake", wakeDataErr - w0, 0);
    check(grants == g0, "R7 no grant on null", grants - g0, 0);
  endtask

  task automatic testMember;
    int r0 = riseTot, w0 = wakeDataErr, g0 = grants, p0 = phaseErr;
    ringDataIn = 1'b0;
    waitRises(r0 + 6);
    ringDataIn = 1'b1; cycles(1);
    check(ringDataOut === 1'b1, "R8 forward high", ringDataOut, 1);
    ringDataIn = 1'b0; cycles(1);
    check(ringDataOut === 1'b0, "R8 forward low", ringDataOut, 0);
    ringDataIn = 1'b1;
    waitPwrLow("R8 member done");
    check(riseTot - r0 == 5 + MSG, "R8 owned edges", riseTot - r0, 5 + MSG);
    check(grants == g0, "R7 member wins", grants - g0, 0);
    check(wakeDataErr == w0, "R6 data high with din low", wakeDataErr - w0, 0);
    check(dataRiseSinceClk == 3, "R9 interrupt after data", dataRiseSinceClk, 3);
    check(phaseErr == p0, "R4 phase lengths owned", phaseErr - p0, 0);
  endtask

  task automatic testLocal;
    int r0 = riseTot, g0 = grants;
    localTxReq = 1'b1; cycles(1); localTxReq = 1'b0;
    waitPwrLow("R7 local done");
    check(grants - g0 == 1, "R7 local grant", grants - g0, 1);
    check(riseTot - r0 == 5 + MSG, "R8 local edges", riseTot - r0, 5 + MSG);
  endtask

  task automatic testContend;
    int r0 = riseTot, g0 = grants, pf0 = pwrFalls;
    ringDataIn = 1'b0;
    localTxReq = 1'b1; cycles(1); localTxReq = 1'b0;
    waitRises(r0 + 6);
    ringDataIn = 1'b1;
    waitPwrLow("R7 contend done");
    check(grants - g0 == 1, "R7 loser retried", grants - g0, 1);
    check(grantAtRise - r0 == 5 + MSG + 5, "R7 grant in second tx",
          grantAtRise - r0, 5 + MSG + 5);
    check(riseTot - r0 == 2 * (5 + MSG), "R11 two transactions", riseTot - r0, 2 * (5 + MSG));
    check(pwrFalls - pf0 == 1, "R11 pwrReq held between", pwrFalls - pf0, 1);
  endtask

  task automatic testLingerRestart;
    int r0, pf0 = pwrFalls, t = 0;
    localTxReq = 1'b1; cycles(1); localTxReq = 1'b0;
    while (!(dataRiseSinceClk == 3 && pwrReq === 1'b1) && t < 2000) begin cycles(1); t++; end
    cycles(HALF + 2);
    pmuHold = 1'b1;
    cycles(3);
    r0 = riseTot;
    localTxReq = 1'b1; cycles(1); localTxReq = 1'b0;
    cycles(10 * HALF);
    check(riseTot > r0, "R11 restart without ack", riseTot - r0, 1);
    check(pwrFalls == pf0, "R11 no release", pwrFalls - pf0, 0);
    pmuHold = 1'b0;
    waitPwrLow("R11 restart done");
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; ringDataIn = 1'b1; localTxReq = 1'b0; pmuHold = 1'b0;
    cycles(5);
    rstN = 1'b1;
    cycles(2);
    testReset();
    testNull();
    cycles(5);
    testMember();
    cycles(5);
    testLocal();
    cycles(5);
    testContend();
    cycles(5);
    testLingerRestart();
    cycles(5);
    testReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule